// File: doc/BRIEF.md
# Bit-Serial 3x3 Median Filter Core

This core takes the nine pixels of a 3x3 neighbourhood as nine parallel serial lines and returns their median on one serial line. Every operand moves one bit per clock, most significant bit first. A single strobe marks the first bit of each set of nine words. The median leaves the core with its own strobe, a fixed number of clocks later. The core is fully pipelined, so a fresh window may start in every word period.

The median comes from a fixed sorting network in three levels. The first level sorts each row. The second level takes the largest of the row minima, the median of the row middles and the smallest of the row maxima. The third level returns the median of those three values. Each three-input node is built one of two ways, chosen by a parameter. In one build it is a single-stage three-input sorter that keeps three pairwise decision flags. In the other it is a chain of three bit-serial compare-swap stages. The sorter build gives the shorter network latency. The line buffers that form windows from a raster, and any handling of image borders, belong to the surrounding design.

Top module: `serial_median9`

## Requirements
- R1: Each of the nine input lines carries an 8-bit unsigned word, MSB first. `win_start` is high in the cycle that carries the MSB of all nine words. Successive strobes are at least 8 cycles apart.
- R2: The word that follows each output strobe on `med_bit` is the 5th smallest of the nine input words of the matching window.
- R3: `med_start` is high exactly LAT cycles after the cycle in which `win_start` was sampled high, and `med_bit` carries the median MSB in that same cycle. LAT is 3 when `USE_SORT3`=1 (single-stage three-input sorters) and 9 when `USE_SORT3`=0 (chains of two-input compare-swap stages).
- R4: Windows may follow each other with no gap or with idle cycles between them. Every comparison decision restarts at each strobe, so no ordering decided in one window affects the next.
- R5: Equal samples are handled correctly. A window of nine equal values returns that value, and windows with repeated values return the correct order statistic.
- R6: Extreme codes are handled correctly. 8'h00 and 8'hFF in any mix give the correct median, including windows of five of one code and four of the other.
- R7: While `rst_n` is low (synchronous, active low), `med_start` and `med_bit` are 0 from the next clock edge on, whatever the inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_start | input | 1 | High with the MSB of each window's nine words |
| win_bits | input | 9 | Serial pixel lines. Bits 0-2 are row 0, bits 3-5 row 1, bits 6-8 row 2 |
| med_bit | output | 1 | Serial median, MSB first |
| med_start | output | 1 | High with the MSB of each median word |

## Verification
The hardest case to reach is a pair of operands that stay equal until the last bit. Their order is then settled only by the LSB, while decisions taken at the MSB of the previous word still sit in the pairwise state. The stimulus builds windows whose samples share their upper seven bits, so only the LSB breaks the ties. These windows run back to back with windows whose ordering is reversed, and both network builds are driven in parallel from the same lines.

// File: rtl/medsort_pkg.sv
// Shared types for the bit-serial median network.
// Assumes MSB-first operands; a pair's ordering is fixed by its first differing bit.
package medsort_pkg;

    // Ordering of an operand pair as far as the bits seen so far decide it
    typedef enum logic [1:0] {
        REL_TIE  = 2'd0,
        REL_A_HI = 2'd1,
        REL_B_HI = 2'd2
    } rel_e;

    // Fold one more bit pair into an ordering decision
    function automatic rel_e rel_step(rel_e prior, logic a, logic b);
        if (prior != REL_TIE) return prior;
        if (a == b) return REL_TIE;
        return a ? REL_A_HI : REL_B_HI;
    endfunction

endpackage

// File: rtl/bs_rel_track.sv
// Pairwise ordering tracker for two MSB-first serial operands.
// Assumes start is high on the MSB cycle; the decision is cleared there and
// latched at the first differing bit. rel_now already includes the current bit.
module bs_rel_track
    import medsort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic a,
    input  logic b,
    output rel_e rel_now
);
    rel_e rel_q;
    rel_e base;

    // Combine the held decision (or a fresh one at word start) with this bit
    always_comb begin
        base    = start ? REL_TIE : rel_q;
        rel_now = rel_step(base, a, b);
    end

    // Hold the decision for the rest of the word
    always_ff @(posedge clk) begin
        if (!rst_n) rel_q <= REL_TIE;
        else        rel_q <= rel_now;
    end

    // A decision taken on this bit must agree with the bits that made it
    AST_DECIDE_MATCHES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (base == REL_TIE && rel_now == REL_A_HI) |-> (a && !b)); // R2

endmodule

// File: rtl/bs_sort2.sv
// Bit-serial two-input compare-swap stage with one register of latency.
// Assumes MSB-first operands aligned with start_i; equal operands pass unchanged
// (a goes to hi while tied).
module bs_sort2
    import medsort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic a,
    input  logic b,
    output logic hi_o,
    output logic lo_o,
    output logic start_o
);
    rel_e rel;
    logic a_up;
    logic tie_b;
    logic tie_q;

    bs_rel_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .a       (a),
        .b       (b),
        .rel_now (rel)
    );

    // Route operands by the pair decision
    always_comb a_up = (rel != REL_B_HI);

    // Register the routed bits and the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o    <= 1'b0;
            lo_o    <= 1'b0;
            start_o <= 1'b0;
        end else begin
            hi_o    <= a_up ? a : b;
            lo_o    <= a_up ? b : a;
            start_o <= start_i;
        end
    end

    // Output-side tie flag, kept apart from the routing logic
    always_comb tie_b = start_o ? 1'b1 : tie_q;

    // Track whether the output words have been equal so far
    always_ff @(posedge clk) begin
        if (!rst_n) tie_q <= 1'b1;
        else        tie_q <= tie_b && (hi_o == lo_o);
    end

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_b && (hi_o != lo_o)) |-> hi_o); // R2

endmodule

// File: rtl/bs_sort3.sv
// Single-stage bit-serial three-input sorter with one register of latency.
// Keeps three pairwise decisions. Ties are broken by input index (a below b below c),
// which keeps the three ranks a permutation on every bit.
module bs_sort3
    import medsort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic a,
    input  logic b,
    input  logic c,
    output logic min_o,
    output logic mid_o,
    output logic max_o,
    output logic start_o
);
    rel_e r_ab, r_ac, r_bc;
    logic a_gt_b, a_gt_c, b_gt_c;
    logic [1:0] rk_a, rk_b, rk_c;
    logic min_d, mid_d, max_d;

    bs_rel_track u_ab (.clk(clk), .rst_n(rst_n), .start(start_i), .a(a), .b(b), .rel_now(r_ab));
    bs_rel_track u_ac (.clk(clk), .rst_n(rst_n), .start(start_i), .a(a), .b(c), .rel_now(r_ac));
    bs_rel_track u_bc (.clk(clk), .rst_n(rst_n), .start(start_i), .a(b), .b(c), .rel_now(r_bc));

    // Rank each operand by the number of operands it stands above
    always_comb begin
        a_gt_b = (r_ab == REL_A_HI);
        a_gt_c = (r_ac == REL_A_HI);
        b_gt_c = (r_bc == REL_A_HI);
        rk_a   = {1'b0, a_gt_b}  + {1'b0, a_gt_c};
        rk_b   = {1'b0, !a_gt_b} + {1'b0, b_gt_c};
        rk_c   = {1'b0, !a_gt_c} + {1'b0, !b_gt_c};
    end

    // Steer each operand to the output that matches its rank
    always_comb begin
        min_d = c;
        mid_d = c;
        max_d = c;
        if (rk_a == 2'd0) min_d = a; else if (rk_b == 2'd0) min_d = b;
        if (rk_a == 2'd1) mid_d = a; else if (rk_b == 2'd1) mid_d = b;
        if (rk_a == 2'd2) max_d = a; else if (rk_b == 2'd2) max_d = b;
    end

    // Register the sorted bits and the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_o   <= 1'b0;
            mid_o   <= 1'b0;
            max_o   <= 1'b0;
            start_o <= 1'b0;
        end else begin
            min_o   <= min_d;
            mid_o   <= mid_d;
            max_o   <= max_d;
            start_o <= start_i;
        end
    end

    // The three pairwise decisions must never form a cycle
    AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({rk_a == 2'd0, rk_b == 2'd0, rk_c == 2'd0}) &&
        $onehot({rk_a == 2'd2, rk_b == 2'd2, rk_c == 2'd2})); // R2

endmodule

// File: rtl/bs_sort3_chain.sv
// Three-input sorter built from three bit-serial compare-swap stages (3 cycles).
// Side operands are delayed so that all operands of a stage stay bit-aligned.
module bs_sort3_chain (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic a,
    input  logic b,
    input  logic c,
    output logic min_o,
    output logic mid_o,
    output logic max_o,
    output logic start_o
);
    logic hi1, lo1, st1;
    logic hi2, lo2, st2;
    logic c_d, lo1_d, hi2_d;

    bs_sort2 u_s1 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .a(a),     .b(b),   .hi_o(hi1),   .lo_o(lo1),   .start_o(st1));
    bs_sort2 u_s2 (.clk(clk), .rst_n(rst_n), .start_i(st1),     .a(hi1),   .b(c_d), .hi_o(hi2),   .lo_o(lo2),   .start_o(st2));
    bs_sort2 u_s3 (.clk(clk), .rst_n(rst_n), .start_i(st2),     .a(lo1_d), .b(lo2), .hi_o(mid_o), .lo_o(min_o), .start_o(start_o));

    // Alignment registers for the operands that skip a stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_d   <= 1'b0;
            lo1_d <= 1'b0;
            hi2_d <= 1'b0;
        end else begin
            c_d   <= c;
            lo1_d <= lo1;
            hi2_d <= hi2;
        end
    end

    assign max_o = hi2_d;

endmodule

// File: rtl/bs_order3_chk.sv
// Checker: the three outputs of a network node must form a sorted triple,
// judged from the serial output words alone.
module bs_order3_chk (
    input  logic clk,
    input  logic rst_n,
    input  logic st,
    input  logic lo,
    input  logic md,
    input  logic hi
);
    logic tie_lm_q, tie_mh_q;
    logic tie_lm_b, tie_mh_b;

    // Equality-so-far for the low/mid and mid/high output pairs
    always_comb begin
        tie_lm_b = st ? 1'b1 : tie_lm_q;
        tie_mh_b = st ? 1'b1 : tie_mh_q;
    end

    // Track the two tie flags across the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tie_lm_q <= 1'b1;
            tie_mh_q <= 1'b1;
        end else begin
            tie_lm_q <= tie_lm_b && (lo == md);
            tie_mh_q <= tie_mh_b && (md == hi);
        end
    end

    AST_ORDER_LOW_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_lm_b && (lo != md)) |-> md); // R2
    AST_ORDER_MID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tie_mh_b && (md != hi)) |-> hi); // R2

endmodule

// File: rtl/serial_median9.sv
// Bit-serial 3x3 median: row sorts, then max/median/min of the columns of
// row results, then the median of those three. Assumes MSB-first 8-bit
// words with one strobe per window. USE_SORT3 picks one-stage three-input
// sorters (LAT 3) or compare-swap chains (LAT 9).
module serial_median9 #(
    parameter int W         = 8,
    parameter bit USE_SORT3 = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_start,
    input  logic [8:0] win_bits,
    output logic       med_bit,
    output logic       med_start
);
    localparam int NODES    = 7;
    localparam int NODE_LAT = USE_SORT3 ? 1 : 3;
    localparam int MED_LAT  = 3 * NODE_LAT;
    localparam int CW       = $clog2(W);
    localparam logic [CW-1:0] SPAN = CW'(W - 1);

    logic [2:0] n_in  [NODES];
    logic       n_sti [NODES];
    logic       n_lo  [NODES];
    logic       n_md  [NODES];
    logic       n_hi  [NODES];
    logic       n_sto [NODES];

    // Node wiring: 0-2 rows, 3 column minima, 4 column middles, 5 column maxima, 6 final
    assign n_in[0]  = win_bits[2:0];
    assign n_in[1]  = win_bits[5:3];
    assign n_in[2]  = win_bits[8:6];
    assign n_in[3]  = {n_lo[2], n_lo[1], n_lo[0]};
    assign n_in[4]  = {n_md[2], n_md[1], n_md[0]};
    assign n_in[5]  = {n_hi[2], n_hi[1], n_hi[0]};
    assign n_in[6]  = {n_lo[5], n_md[4], n_hi[3]};
    assign n_sti[0] = win_start;
    assign n_sti[1] = win_start;
    assign n_sti[2] = win_start;
    assign n_sti[3] = n_sto[0];
    assign n_sti[4] = n_sto[0];
    assign n_sti[5] = n_sto[0];
    assign n_sti[6] = n_sto[3];

    for (genvar k = 0; k < NODES; k++) begin : g_node
        if (USE_SORT3) begin : g_s3
            bs_sort3 u_n (
                .clk(clk), .rst_n(rst_n), .start_i(n_sti[k]),
                .a(n_in[k][0]), .b(n_in[k][1]), .c(n_in[k][2]),
                .min_o(n_lo[k]), .mid_o(n_md[k]), .max_o(n_hi[k]), .start_o(n_sto[k])
            );
        end else begin : g_cs
            bs_sort3_chain u_n (
                .clk(clk), .rst_n(rst_n), .start_i(n_sti[k]),
                .a(n_in[k][0]), .b(n_in[k][1]), .c(n_in[k][2]),
                .min_o(n_lo[k]), .mid_o(n_md[k]), .max_o(n_hi[k]), .start_o(n_sto[k])
            );
        end
        bs_order3_chk u_chk (
            .clk(clk), .rst_n(rst_n), .st(n_sto[k]),
            .lo(n_lo[k]), .md(n_md[k]), .hi(n_hi[k])
        );
    end

    assign med_bit   = n_md[6];
    assign med_start = n_sto[6];

    // Checker state: strobe delay line and cycles since the last strobe
    logic [MED_LAT-1:0] ws_dly;
    logic [CW-1:0]      since_q;

    // Delay the input strobe by the expected network latency
    always_ff @(posedge clk) begin
        if (!rst_n) ws_dly <= '0;
        else        ws_dly <= {ws_dly[MED_LAT-2:0], win_start};
    end

    // Count cycles since the last strobe, saturating at one word
    always_ff @(posedge clk) begin
        if (!rst_n)               since_q <= SPAN;
        else if (win_start)       since_q <= '0;
        else if (since_q != SPAN) since_q <= since_q + 1'b1;
    end

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |-> (since_q == SPAN)); // R1
    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        med_start == ws_dly[MED_LAT-1]); // R3
    AST_STAGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (n_sto[0] == n_sto[1]) && (n_sto[1] == n_sto[2]) &&
        (n_sto[3] == n_sto[4]) && (n_sto[4] == n_sto[5])); // R4
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!med_start && !med_bit)); // R7

endmodule

// File: tb/sim_serial_median9.sv
module sim_serial_median9;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_start = 1'b0;
    logic [8:0] win_bits = '0;
    logic       med0, ms0, med1, ms1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ws_cyc = -1;
    int first0 = -1;
    int first1 = -1;
    int cnt0 = 0;
    int cnt1 = 0;
    logic [7:0] acc0, acc1;
    int exp_q[$];
    int got0[$];
    int got1[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_median9 #(.W(W), .USE_SORT3(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_bits(win_bits),
        .med_bit(med0), .med_start(ms0));
    serial_median9 #(.W(W), .USE_SORT3(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_bits(win_bits),
        .med_bit(med1), .med_start(ms1));

    // Deserialise both outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ms0) begin acc0 = {7'b0, med0}; cnt0 = 1; if (first0 < 0) first0 = cyc; end
            else if (cnt0 > 0) begin acc0 = {acc0[6:0], med0}; cnt0++; end
            if (cnt0 == W) begin got0.push_back(int'(acc0)); cnt0 = 0; end
            if (ms1) begin acc1 = {7'b0, med1}; cnt1 = 1; if (first1 < 0) first1 = cyc; end
            else if (cnt1 > 0) begin acc1 = {acc1[6:0], med1}; cnt1++; end
            if (cnt1 == W) begin got1.push_back(int'(acc1)); cnt1 = 0; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int med9(input logic [7:0] p[9]);
        int v[9];
        for (int i = 0; i < 9; i++) v[i] = int'(p[i]);
        for (int i = 1; i < 9; i++)
            for (int j = i; j > 0 && v[j-1] > v[j]; j--) begin
                int t = v[j]; v[j] = v[j-1]; v[j-1] = t;
            end
        return v[4];
    endfunction

    task automatic begin_test();
        exp_q.delete(); got0.delete(); got1.delete();
        first0 = -1; first1 = -1; ws_cyc = -1;
    endtask

    task automatic send(input logic [7:0] p[9], input int gap);
        for (int b = W - 1; b >= 0; b--) begin
            @(negedge clk);
            win_start = (b == W - 1);
            if (b == W - 1 && ws_cyc < 0) ws_cyc = cyc;
            for (int i = 0; i < 9; i++) win_bits[i] = p[i][b];
        end
        exp_q.push_back(med9(p));
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            win_start = 1'b0;
            win_bits = 9'($urandom);
        end
    endtask

    task automatic flush_and_compare(input string req);
        @(negedge clk);
        win_start = 1'b0;
        repeat (9 + W + 4) @(negedge clk);
        check(got0.size() == exp_q.size(), {req, " count sort3"}, got0.size(), exp_q.size());
        check(got1.size() == exp_q.size(), {req, " count chain"}, got1.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < got0.size()) check(got0[i] == exp_q[i], {req, " median sort3"}, got0[i], exp_q[i]);
            if (i < got1.size()) check(got1[i] == exp_q[i], {req, " median chain"}, got1[i], exp_q[i]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            win_start = 1'($urandom);
            win_bits = 9'($urandom);
            @(negedge clk);
            check({ms0, med0, ms1, med1} == 4'b0, "R7 outputs low in reset", {ms0, med0, ms1, med1}, 0);
        end
        win_start = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        logic [7:0] p[9] = '{8'd12, 8'd200, 8'd7, 8'd99, 8'd45, 8'd150, 8'd3, 8'd77, 8'd64};
        begin_test();
        send(p, 0);
        flush_and_compare("R3");
        check(first0 - ws_cyc == 3, "R3 latency sort3", first0 - ws_cyc, 3);
        check(first1 - ws_cyc == 9, "R3 latency chain", first1 - ws_cyc, 9);
    endtask

    task automatic t_equal();
        logic [7:0] p[9];
        begin_test();
        p = '{default: 8'h5A};
        send(p, 0);
        p = '{8'd7, 8'd7, 8'd7, 8'd7, 8'd3, 8'd3, 8'd9, 8'd9, 8'd9};
        send(p, 1);
        p = '{8'd40, 8'd40, 8'd10, 8'd40, 8'd90, 8'd10, 8'd90, 8'd10, 8'd90};
        send(p, 0);
        flush_and_compare("R5");
    endtask

    task automatic t_extremes();
        logic [7:0] p[9];
        begin_test();
        p = '{default: 8'h00}; send(p, 0);
        p = '{default: 8'hFF}; send(p, 0);
        p = '{8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF}; send(p, 0);
        p = '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00}; send(p, 2);
        p = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h80}; send(p, 0);
        flush_and_compare("R6");
    endtask

    task automatic t_late_ties();
        logic [7:0] p[9];
        begin_test();
        for (int n = 0; n < 12; n++) begin
            logic [6:0] hi7 = 7'($urandom);
            for (int i = 0; i < 9; i++) p[i] = {hi7, 1'($urandom)};
            send(p, 0);
        end
        flush_and_compare("R4 late ties");
    endtask

    task automatic t_alternate();
        logic [7:0] up[9] = '{8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60, 8'd70, 8'd80, 8'd90};
        logic [7:0] dn[9] = '{8'd90, 8'd80, 8'd70, 8'd60, 8'd50, 8'd40, 8'd30, 8'd21, 8'd11};
        logic [7:0] mx[9] = '{8'd200, 8'd1, 8'd130, 8'd129, 8'd128, 8'd127, 8'd126, 8'd255, 8'd0};
        begin_test();
        for (int n = 0; n < 4; n++) begin
            send(up, 0);
            send(dn, n);
            send(mx, 0);
        end
        flush_and_compare("R4 alternate");
    endtask

    task automatic t_random();
        logic [7:0] p[9];
        begin_test();
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < 9; i++) p[i] = 8'($urandom);
            send(p, int'($urandom_range(0, 3)));
        end
        flush_and_compare("R1 R2 random");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        t_latency();
        t_equal();
        t_extremes();
        t_late_ties();
        t_alternate();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule